// File: doc/BRIEF.md
# Receive Ring Buffer Page Manager

This block places incoming frames into a circular receive area of local memory made of 256-byte pages. Software owns four page pointers: the first page of the ring, the page just past its last page, a boundary page marking the oldest data not yet read, and the current page where the next frame will start. Frames arrive as a start strobe, a stream of bytes and an end strobe that carries the error and match flags produced upstream. Each byte goes straight to memory, starting four bytes into the current page. The page address wraps from the last ring page back to the first.

Once the end strobe arrives, the block decides whether to keep the frame. A kept frame gets a 4-byte header, written last at offset 0 of its first page. The header holds the receive status, the page where the next frame will start, and the byte count, which is the frame length plus four. The current-page pointer then moves to that next page. A discarded frame leaves the current page unchanged, and any data it already wrote is abandoned. Discard reasons are:
- too short, unless runts are accepted;
- a CRC or alignment error, unless errored frames are saved;
- a FIFO overrun;
- monitor mode;
- a frame that would run into the boundary page.

For every frame the block drives a one-cycle event pulse for the interrupt logic and holds the frame's status byte.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset all four pointers are 0, `cur_page` is 0, `rx_status` is 0, and no memory write or event is driven.
- R2: Byte k (counting from 0) of a frame is written at linear offset 4+k from offset 0 of the frame's start page, which is the current page at the start strobe. Writes run on through successive pages.
- R3: A page increment from page-stop minus 1 continues at page-start. All data writes stay inside the ring.
- R4: A kept frame gets four header writes after its end strobe, at offsets 0 to 3 of its start page. The bytes are, in order: the status byte, the next-packet page, the count low byte and the count high byte. The count equals the frame length plus 4.
- R5: The next-packet page is the start page plus ceil((length+4)/256), wrapped into the ring. After a kept frame `cur_page` takes this value.
- R6: Let d be the distance from the start page forward to the boundary page, counted modulo the ring size, where a distance of 0 counts as the full ring. If ceil((length+4)/256) >= d, the frame is not kept. In that case `ev_ovw` pulses and status bit 4 is set.
- R7: A frame shorter than 64 bytes is not kept unless `accept_runt` is 1.
- R8: A frame flagged with a CRC or alignment error is not kept unless `save_err` is 1. If it is kept, status bit 0 is 0.
- R9: A frame flagged with a FIFO overrun is never kept, and status bit 3 is set.
- R10: While `monitor` is 1, frames cause no memory write, are not kept, and set status bit 4.
- R11: Status byte layout:
  - bit 0: kept without error
  - bit 1: CRC error
  - bit 2: alignment error
  - bit 3: FIFO overrun
  - bit 4: missed (monitor mode or overwrite)
  - bit 5: multicast/broadcast match
  - bits 7:6: 0

  After each frame, `ev_ok` pulses once if bit 0 is set, and `ev_err` pulses once if any of bits 1 to 4 is set. The pulse comes in the cycle after the last header write for a kept frame, or the cycle after the end strobe for a discarded one.
- R12: A host write with `hw_sel` 0, 1, 2 or 3 loads page-start, page-stop, boundary or current page respectively. A current-page write shows on `cur_page` on the next cycle.
- R13: A frame that is not kept writes no header; offsets 0 to 3 of its start page stay untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hw_en | input | 1 | Host pointer write strobe |
| hw_sel | input | 2 | Pointer select: 0 start, 1 stop, 2 boundary, 3 current |
| hw_data | input | 8 | Pointer value |
| accept_runt | input | 1 | Keep frames shorter than 64 bytes |
| save_err | input | 1 | Keep frames with CRC or alignment errors |
| monitor | input | 1 | Check frames without storing them |
| rx_sof | input | 1 | Frame start strobe |
| rx_byte_vld | input | 1 | Frame data byte valid |
| rx_byte | input | 8 | Frame data byte |
| rx_eof | input | 1 | Frame end strobe; flags valid with it |
| rx_crc_err | input | 1 | CRC error flag |
| rx_align_err | input | 1 | Alignment error flag |
| rx_fifo_ovr | input | 1 | FIFO overrun flag |
| rx_mcast | input | 1 | Multicast/broadcast match flag |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address {page, offset} |
| mem_wdata | output | 8 | Memory write data |
| ev_ok | output | 1 | Frame kept without error (pulse) |
| ev_err | output | 1 | Frame had an error or was missed (pulse) |
| ev_ovw | output | 1 | Boundary overwrite detected (pulse) |
| rx_status | output | 8 | Status byte of the last frame |
| cur_page | output | 8 | Current page pointer |

## Verification
Directed frames are placed right at the page limits: lengths 251, 252 and 253, with the boundary one or two pages ahead. These separate a frame that exactly fills its page from one that spills into the boundary, which tests the ceiling in the page count. A frame starting on the last ring page checks the wrap of both the data address and the next-packet page. Runt, CRC, alignment, FIFO-overrun and monitor frames are each sent with and without the matching keep option. This tells apart a frame that is dropped from one that is kept with a clear OK bit. Random lengths, boundaries, flags and options then cover how the keep rules interact, each frame checked against a page-arithmetic model of the header, the data bytes, the current page and the event pulses.

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr #(
  parameter int PG_W     = 8,
  parameter int LEN_W    = 16,
  parameter int RUNT_MIN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_en,
  input  logic [1:0]        hw_sel,
  input  logic [PG_W-1:0]   hw_data,
  input  logic              accept_runt,
  input  logic              save_err,
  input  logic              monitor,
  input  logic              rx_sof,
  input  logic              rx_byte_vld,
  input  logic [7:0]        rx_byte,
  input  logic              rx_eof,
  input  logic              rx_crc_err,
  input  logic              rx_align_err,
  input  logic              rx_fifo_ovr,
  input  logic              rx_mcast,
  output logic              mem_we,
  output logic [PG_W+7:0]   mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              ev_ok,
  output logic              ev_err,
  output logic              ev_ovw,
  output logic [7:0]        rx_status,
  output logic [PG_W-1:0]   cur_page
);

  localparam logic [7:0]       HDR_LEN = 8'd4;
  localparam logic [LEN_W-1:0] CNT_ADD = LEN_W'(4);

  typedef enum logic [1:0] {S_IDLE, S_RECV, S_HDR, S_FIN} state_t;

  state_t            state_q;
  logic [PG_W-1:0]   pstart_q, pstop_q, bnry_q, curr_q;
  logic [PG_W-1:0]   start_q, wpage_q, nxt_q;
  logic [7:0]        wofs_q;
  logic [LEN_W-1:0]  len_q;
  logic              ovf_q, kept_q, ovw_q;
  logic [7:0]        st_q;
  logic [1:0]        hidx_q;

  logic [PG_W-1:0]   pg_plus, pg_inc, end_pg;
  logic              wr_byte, byte_we, ovw_now, runt, err, keep;
  logic [7:0]        status;
  logic [LEN_W-1:0]  cnt;

  assign pg_plus = wpage_q + 1'b1;
  assign pg_inc  = (pg_plus == pstop_q) ? pstart_q : pg_plus;
  assign end_pg  = (wofs_q == 8'd0) ? wpage_q : pg_inc;

  assign wr_byte = (state_q == S_RECV) && rx_byte_vld && !rx_eof && !monitor;
  assign byte_we = wr_byte && !ovf_q;

  assign ovw_now = ovf_q || (end_pg == bnry_q);
  assign runt    = len_q < LEN_W'(RUNT_MIN);
  assign err     = rx_crc_err || rx_align_err;
  assign keep    = !monitor && !ovw_now && !rx_fifo_ovr &&
                   (!runt || accept_runt) && (!err || save_err);
  assign status  = {2'b00, rx_mcast, monitor || ovw_now, rx_fifo_ovr,
                    rx_align_err, rx_crc_err, keep && !err};
  assign cnt     = len_q + CNT_ADD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      pstart_q <= '0;
      pstop_q  <= '0;
      bnry_q   <= '0;
      curr_q   <= '0;
      start_q  <= '0;
      wpage_q  <= '0;
      nxt_q    <= '0;
      wofs_q   <= '0;
      len_q    <= '0;
      ovf_q    <= 1'b0;
      kept_q   <= 1'b0;
      ovw_q    <= 1'b0;
      st_q     <= '0;
      hidx_q   <= '0;
    end else begin
      if (hw_en) begin
        case (hw_sel)
          2'd0:    pstart_q <= hw_data;
          2'd1:    pstop_q  <= hw_data;
          2'd2:    bnry_q   <= hw_data;
          default: curr_q   <= hw_data;
        endcase
      end
      case (state_q)
        S_IDLE: begin
          if (rx_sof) begin
            start_q <= curr_q;
            wpage_q <= curr_q;
            wofs_q  <= HDR_LEN;
            len_q   <= '0;
            ovf_q   <= 1'b0;
            state_q <= S_RECV;
          end
        end
        S_RECV: begin
          if (rx_eof) begin
            st_q    <= status;
            kept_q  <= keep;
            ovw_q   <= ovw_now && !monitor;
            nxt_q   <= end_pg;
            hidx_q  <= '0;
            state_q <= keep ? S_HDR : S_FIN;
          end else if (rx_byte_vld) begin
            len_q <= len_q + 1'b1;
            if (wr_byte) begin
              wofs_q <= wofs_q + 1'b1;
              if (wofs_q == 8'hFF) begin
                wpage_q <= pg_inc;
                if (pg_inc == bnry_q) ovf_q <= 1'b1;
              end
            end
          end
        end
        S_HDR: begin
          hidx_q <= hidx_q + 1'b1;
          if (hidx_q == 2'd3) begin
            curr_q  <= nxt_q;
            state_q <= S_FIN;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = {wpage_q, wofs_q};
    mem_wdata = rx_byte;
    if (state_q == S_HDR) begin
      mem_we   = 1'b1;
      mem_addr = {start_q, 6'd0, hidx_q};
      case (hidx_q)
        2'd0:    mem_wdata = st_q;
        2'd1:    mem_wdata = 8'(nxt_q);
        2'd2:    mem_wdata = cnt[7:0];
        default: mem_wdata = cnt[15:8];
      endcase
    end else if (byte_we) begin
      mem_we = 1'b1;
    end
  end

  assign ev_ok     = (state_q == S_FIN) && st_q[0];
  assign ev_err    = (state_q == S_FIN) && (|st_q[4:1]);
  assign ev_ovw    = (state_q == S_FIN) && ovw_q;
  assign rx_status = st_q;
  assign cur_page  = curr_q;

  AST_RING_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we && pstart_q < pstop_q && curr_q >= pstart_q && curr_q < pstop_q)
      |-> (mem_addr[PG_W+7:8] >= pstart_q && mem_addr[PG_W+7:8] < pstop_q)); // R3
  AST_MON_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RECV && monitor) |-> !mem_we); // R10
  AST_EV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_ok && ev_err)); // R11
  AST_OVW_MISSED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovw |-> (rx_status[4] && !ev_ok)); // R6
  AST_FIFO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_FIN) && rx_status[3]) |-> !kept_q); // R9
  AST_EVENT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ok || ev_err) |=> !(ev_ok || ev_err)); // R11

endmodule

// File: tb/rx_ring_mgr_bench.sv
`timescale 1ns/1ps
module rx_ring_mgr_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hw_en = 0; logic [1:0] hw_sel = 0; logic [7:0] hw_data = 0;
  logic accept_runt = 0, save_err = 0, monitor = 0;
  logic rx_sof = 0, rx_byte_vld = 0, rx_eof = 0;
  logic [7:0] rx_byte = 0;
  logic rx_crc_err = 0, rx_align_err = 0, rx_fifo_ovr = 0, rx_mcast = 0;
  logic mem_we, ev_ok, ev_err, ev_ovw;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, rx_status, cur_page;

  rx_ring_mgr u_rx_ring_mgr (.*);

  always #2.5 clk = ~clk;

  localparam int PSTART = 'h40, PSTOP = 'h4C, RING = PSTOP - PSTART;

  int n_chk = 0, n_fail = 0;
  int nwr, nok, nerr, novw;
  int ecur;
  logic [7:0] mem [4096];

  always @(negedge clk) begin
    if (mem_we) begin mem[mem_addr[11:0]] = mem_wdata; nwr++; end
    if (ev_ok) nok++;
    if (ev_err) nerr++;
    if (ev_ovw) novw++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int mi(input int page, input int off);
    return ((page & 15) << 8) | off;
  endfunction

  function automatic int wrapg(input int p);
    int q = p;
    while (q >= PSTOP) q -= RING;
    return q;
  endfunction

  function automatic logic [7:0] pat(input int k, input int len);
    return 8'((k * 7 + len * 3) & 255);
  endfunction

  task automatic host_wr(input int sel, input int val);
    @(posedge clk); #1 hw_en = 1; hw_sel = 2'(sel); hw_data = 8'(val);
    @(posedge clk); #1 hw_en = 0;
  endtask

  task automatic send(input int len, input bit crc, input bit al, input bit fo, input bit mc);
    @(posedge clk); #1 rx_sof = 1;
    @(posedge clk); #1 rx_sof = 0;
    for (int k = 0; k < len; k++) begin
      rx_byte_vld = 1; rx_byte = pat(k, len);
      @(posedge clk); #1;
    end
    rx_byte_vld = 0; rx_eof = 1;
    rx_crc_err = crc; rx_align_err = al; rx_fifo_ovr = fo; rx_mcast = mc;
    @(posedge clk); #1 rx_eof = 0;
    rx_crc_err = 0; rx_align_err = 0; rx_fifo_ovr = 0; rx_mcast = 0;
    repeat (8) @(posedge clk);
  endtask

  task automatic frame(input int len, input bit crc, input bit al, input bit fo,
                       input bit mc, input bit ar, input bit sep, input bit mon,
                       input int bn);
    int start, total, np, d, nxt, lin, pg;
    bit ovw, err, runt, kept;
    logic [7:0] est;
    string tag;
    accept_runt = ar; save_err = sep; monitor = mon;
    host_wr(2, bn);
    start = ecur;
    total = len + 4;
    np    = (total + 255) / 256;
    d     = (bn > start) ? bn - start : bn - start + RING;
    ovw   = (np >= d);
    nxt   = wrapg(start + np);
    err   = crc | al;
    runt  = len < 64;
    kept  = !mon && !ovw && !fo && (!runt || ar) && (!err || sep);
    est   = {2'b00, mc, mon | ovw, fo, al, crc, kept & !err};
    if (mon) tag = "R10";
    else if (fo) tag = "R9";
    else if (ovw) tag = "R6";
    else if (runt && !ar) tag = "R7";
    else if (err && !sep) tag = "R8";
    else tag = "R5";
    for (int i = 0; i < 4; i++) mem[mi(start, i)] = 8'hA5;
    nwr = 0; nok = 0; nerr = 0; novw = 0;
    send(len, crc, al, fo, mc);
    if (kept) ecur = nxt;
    chk(cur_page == 8'(ecur), tag, "cur_page", cur_page, ecur);
    chk(rx_status == est, "R11", "status", rx_status, est);
    chk(nok == int'(est[0]), "R11", "ev_ok count", nok, est[0]);
    chk(nerr == int'(|est[4:1]), "R11", "ev_err count", nerr, |est[4:1]);
    chk(novw == int'(ovw && !mon), "R6", "ev_ovw count", novw, ovw && !mon);
    if (mon) chk(nwr == 0, "R10", "writes in monitor", nwr, 0);
    if (kept) begin
      chk(mem[mi(start, 0)] == est, "R4", "hdr status", mem[mi(start, 0)], est);
      chk(mem[mi(start, 1)] == 8'(nxt), "R4", "hdr next", mem[mi(start, 1)], nxt);
      chk(mem[mi(start, 2)] == 8'(total), "R4", "hdr cnt lo", mem[mi(start, 2)], total & 255);
      chk(mem[mi(start, 3)] == 8'(total >> 8), "R4", "hdr cnt hi", mem[mi(start, 3)], total >> 8);
      if (len > 0) begin
        chk(mem[mi(start, 4)] == pat(0, len), "R2", "first byte", mem[mi(start, 4)], pat(0, len));
        lin = 4 + len - 1;
        pg  = wrapg(start + lin / 256);
        chk(mem[mi(pg, lin % 256)] == pat(len - 1, len),
            (pg < start) ? "R3" : "R2", "last byte", mem[mi(pg, lin % 256)], pat(len - 1, len));
      end
    end else begin
      for (int i = 0; i < 4; i++)
        chk(mem[mi(start, i)] == 8'hA5, "R13", "no header", mem[mi(start, i)], 8'hA5);
    end
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cur_page == 8'h00, "R1", "reset cur_page", cur_page, 0);
    chk(rx_status == 8'h00, "R1", "reset status", rx_status, 0);
    chk(!mem_we && !ev_ok && !ev_err && !ev_ovw, "R1", "reset outputs",
        {mem_we, ev_ok, ev_err, ev_ovw}, 0);
    #1 rst_n = 1;

    host_wr(0, PSTART); host_wr(1, PSTOP); host_wr(3, 'h41);
    @(negedge clk);
    chk(cur_page == 8'h41, "R12", "host cur write", cur_page, 'h41);
    ecur = 'h41;

    frame(100, 0, 0, 0, 0, 0, 0, 0, 'h40);
    host_wr(3, 'h4B); ecur = 'h4B;
    frame(300, 0, 0, 0, 1, 0, 0, 0, 'h45);
    chk(cur_page == 8'h41, "R3", "wrap next page", cur_page, 'h41);

    host_wr(3, 'h44); ecur = 'h44;
    frame(252, 0, 0, 0, 0, 0, 0, 0, 'h46);
    frame(253, 0, 0, 0, 0, 0, 0, 0, 'h47);
    frame(251, 0, 0, 0, 0, 0, 0, 0, 'h46);
    frame(251, 0, 0, 0, 0, 0, 0, 0, 'h48);
    frame(40, 0, 0, 0, 0, 0, 0, 0, 'h40);
    frame(40, 0, 0, 0, 0, 1, 0, 0, 'h40);
    frame(63, 0, 0, 0, 0, 0, 0, 0, 'h40);
    frame(64, 0, 0, 0, 0, 0, 0, 0, 'h40);
    frame(120, 1, 0, 0, 0, 0, 0, 0, 'h40);
    frame(120, 1, 0, 0, 0, 0, 1, 0, 'h40);
    frame(120, 0, 1, 0, 0, 0, 0, 0, 'h40);
    frame(120, 0, 1, 0, 0, 0, 1, 0, 'h40);
    frame(120, 0, 0, 1, 0, 1, 1, 0, 'h40);
    frame(120, 0, 0, 0, 1, 1, 1, 1, 'h40);

    for (int n = 0; n < 110; n++) begin
      int len = 20 + int'($urandom % 580);
      frame(len, ($urandom % 8) == 0, ($urandom % 10) == 0, ($urandom % 14) == 0,
            ($urandom % 3) == 0, ($urandom % 2) == 1, ($urandom % 2) == 1,
            ($urandom % 12) == 0, PSTART + int'($urandom % RING));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule